// File: doc/BRIEF.md
# SPI Burst Master Controller

A register-mapped SPI master that runs one burst per start request. Software sets two byte counts: the total length of the burst, and how many of those bytes are taken from a 64-byte transmit queue. It fills the queue and then sets a start bit. The controller drops chip select and shifts the queued bytes out MSB first in SPI mode 0. After the transmit count is used up, it keeps clocking zero bytes until the total is reached. Every byte shifted in from the slave goes into a 64-byte receive queue. This includes the bytes that arrive while command bytes are still going out. A typical flash read therefore sends four command/address bytes with a total of four plus N, then discards the first four received bytes.

The register map uses 3-bit word addresses: 0 control, 1 clock setup, 2 burst length, 3 transmit length, 4 transmit data (a write pushes), 5 receive data (a read pops), 6 status. The sequencer has five named states:
- IDLE: waiting for a start request.
- LOAD: fetching the next byte.
- LOW: serial clock low.
- HIGH: serial clock high.
- FIN: releasing chip select and clearing the start bit.

The transitions are:
- IDLE to LOAD on start.
- IDLE to FIN on a start with a zero burst length.
- LOAD to LOW always.
- LOW to HIGH at the end of a half period.
- HIGH to LOW at the end of a half period after bits 0 to 6.
- HIGH to LOAD after bit 7 when bytes remain.
- HIGH to FIN after bit 7 of the last byte.
- FIN to IDLE always.
- Any state to IDLE on soft reset.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the control and status registers read 0, chip select (active low) is high and the serial clock is low.
- R2: A burst starts only from a write to control (address 0) with bit 0 (enable), bit 1 (master) and bit 4 (start) all set. A write that sets start without both enable and master produces no chip-select activity, and bit 4 reads back 0.
- R3: A burst holds chip select low for exactly 8 x (burst length, address 2) rising clock edges and releases it after the last bit. Control bit 4 reads 1 while the burst runs and clears itself when the burst ends.
- R4: The first min(transmit length, burst length) bytes are popped from the transmit queue (written at address 4) and sent MSB first. All later bytes of the burst send 0, as does any byte due while the queue is empty. Unsent queued bytes stay queued.
- R5: The receive line is sampled on each rising clock edge, MSB first, and every byte of the burst, including those received during the transmit phase, is pushed into the receive queue. A read of address 5 pops the oldest byte into bits [7:0]. Status (address 6) bits [6:0] give the receive level and bits [14:8] give the transmit level.
- R6: SPI mode 0. The serial clock is low whenever chip select is high, and the data output does not change while the serial clock is high.
- R7: With bit 12 of the clock setup register (address 1) set, each clock half period lasts bits [7:0] + 1 system cycles, so 0x1001 divides by 4. With bit 12 clear, the half period is 1 cycle.
- R8: Each queue holds 64 bytes. A write to a full transmit queue is dropped. A read of the empty receive queue returns 0 and leaves the level at 0. Receive bytes beyond 64 are dropped and the oldest 64 are kept.
- R9: Writing control bit 2 empties the transmit queue and writing control bit 3 empties the receive queue. Both bits read back 0.
- R10: Writing control bit 7 requests a soft reset. The bit reads 1 for the following cycle and then clears itself. The reset aborts any burst and returns every register and both queues to their reset values.
- R11: A start with a burst length of 0 clears bit 4 again without asserting chip select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The bench focuses on the phase boundaries:
- A transmit length larger than the burst. A design that ignored the burst limit would keep clocking and drain the extra queued byte.
- A transmit length with an empty queue. A design that did not gate the pop would send stale data instead of zeros.
- The first bytes received during the command phase. A design that skipped them would misalign every later byte.

It also starts a zero-length burst, which a wrong design would hang on or frame with chip select. It overfills both queues, where an off-by-one level would show 65 or lose the oldest byte. It aborts a burst with soft reset, which a design without a proper abort would leave with chip select stuck low or with stale queue levels.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH, ST_FIN} eng_state_t;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_CLK    = 3'd1;
    localparam logic [2:0] A_BURST  = 3'd2;
    localparam logic [2:0] A_TXCNT  = 3'd3;
    localparam logic [2:0] A_TXDATA = 3'd4;
    localparam logic [2:0] A_RXDATA = 3'd5;
    localparam logic [2:0] A_STATUS = 3'd6;

    localparam int B_EN     = 0;
    localparam int B_MST    = 1;
    localparam int B_TXCLR  = 2;
    localparam int B_RXCLR  = 3;
    localparam int B_XCH    = 4;
    localparam int B_SRST   = 7;
    localparam int B_DIVEN  = 12;
    localparam int TXLVL_LO = 8;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != LW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    assign dout  = (cnt == '0) ? '0 : mem[rp];
    assign level = cnt;
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int CW = 8,
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [CW-1:0] burst_len,
    input  logic [CW-1:0] tx_len,
    input  logic [HW-1:0] half_per,
    input  logic          tx_avail,
    input  logic [7:0]    tx_byte,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [7:0]    rx_byte,
    output logic          done,
    output logic          sck,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);
    eng_state_t    state, nxt;
    logic [HW-1:0] hcnt;
    logic [2:0]    bitn;
    logic [CW-1:0] left, txleft;
    logic [7:0]    shreg, rxsh;
    logic          half_end;

    assign half_end = (hcnt == half_per - HW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = (burst_len == '0) ? ST_FIN : ST_LOAD;
            ST_LOAD: nxt = ST_LOW;
            ST_LOW:  if (half_end) nxt = ST_HIGH;
            ST_HIGH: if (half_end) begin
                         if (bitn != 3'd7)        nxt = ST_LOW;
                         else if (left == CW'(1)) nxt = ST_FIN;
                         else                     nxt = ST_LOAD;
                     end
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0; bitn <= '0; left <= '0; txleft <= '0;
            shreg <= '0; rxsh <= '0;
        end else if (abort) begin
            hcnt <= '0; bitn <= '0; left <= '0; txleft <= '0;
            shreg <= '0; rxsh <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    left   <= burst_len;
                    txleft <= tx_len;
                end
                ST_LOAD: begin
                    shreg <= (txleft != '0 && tx_avail) ? tx_byte : 8'h00;
                    if (txleft != '0) txleft <= txleft - CW'(1);
                    bitn <= '0;
                    hcnt <= '0;
                end
                ST_LOW: begin
                    if (half_end) begin
                        hcnt <= '0;
                        rxsh <= {rxsh[6:0], miso};
                    end else hcnt <= hcnt + HW'(1);
                end
                ST_HIGH: begin
                    if (half_end) begin
                        hcnt <= '0;
                        if (bitn == 3'd7) left <= left - CW'(1);
                        else begin
                            shreg <= {shreg[6:0], 1'b0};
                            bitn  <= bitn + 3'd1;
                        end
                    end else hcnt <= hcnt + HW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sck     = (state == ST_HIGH);
        cs_n    = !(state == ST_LOAD || state == ST_LOW || state == ST_HIGH);
        mosi    = !cs_n && shreg[7];
        tx_pop  = (state == ST_LOAD) && (txleft != '0);
        rx_push = (state == ST_HIGH) && half_end && (bitn == 3'd7);
        rx_byte = rxsh;
        done    = (state == ST_FIN);
    end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          spi_sck,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int HW = 9;

    logic          en, mst, xch, srst_pend;
    logic [DW-1:0] clkcfg;
    logic [CW-1:0] burst_r, txcnt_r;
    logic          ctrl_wr, start, eng_done;
    logic          tx_push, tx_pop, rx_push, rx_pop, txf_clr, rxf_clr;
    logic [7:0]    tx_dout, rx_dout, rx_byte;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic [HW-1:0] half_per;

    assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign start    = ctrl_wr && bus_wdata[B_EN] && bus_wdata[B_MST] && bus_wdata[B_XCH]
                      && !xch && !srst_pend;
    assign txf_clr  = srst_pend || (ctrl_wr && bus_wdata[B_TXCLR]);
    assign rxf_clr  = srst_pend || (ctrl_wr && bus_wdata[B_RXCLR]);
    assign tx_push  = bus_sel && bus_wr && (bus_addr == A_TXDATA) && !srst_pend;
    assign rx_pop   = bus_sel && !bus_wr && (bus_addr == A_RXDATA);
    assign half_per = clkcfg[B_DIVEN] ? ({1'b0, clkcfg[7:0]} + HW'(1)) : HW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0; mst <= 1'b0; xch <= 1'b0; srst_pend <= 1'b0;
            clkcfg <= '0; burst_r <= '0; txcnt_r <= '0;
        end else if (srst_pend) begin
            en <= 1'b0; mst <= 1'b0; xch <= 1'b0; srst_pend <= 1'b0;
            clkcfg <= '0; burst_r <= '0; txcnt_r <= '0;
        end else begin
            if (ctrl_wr) begin
                en        <= bus_wdata[B_EN];
                mst       <= bus_wdata[B_MST];
                srst_pend <= bus_wdata[B_SRST];
            end
            if (start)         xch <= 1'b1;
            else if (eng_done) xch <= 1'b0;
            if (bus_sel && bus_wr && bus_addr == A_CLK)   clkcfg  <= bus_wdata;
            if (bus_sel && bus_wr && bus_addr == A_BURST) burst_r <= bus_wdata[CW-1:0];
            if (bus_sel && bus_wr && bus_addr == A_TXCNT) txcnt_r <= bus_wdata[CW-1:0];
        end
    end

    spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(txf_clr),
        .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .level(tx_lvl)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rxf_clr),
        .push(rx_push && !srst_pend), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .level(rx_lvl)
    );

    spi_burst_engine #(.CW(CW), .HW(HW)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(srst_pend), .start(start),
        .burst_len(burst_r), .tx_len(txcnt_r), .half_per(half_per),
        .tx_avail(tx_lvl != '0), .tx_byte(tx_dout), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .done(eng_done),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]   = en;
                bus_rdata[B_MST]  = mst;
                bus_rdata[B_XCH]  = xch;
                bus_rdata[B_SRST] = srst_pend;
            end
            A_CLK:    bus_rdata = clkcfg;
            A_BURST:  bus_rdata[CW-1:0] = burst_r;
            A_TXCNT:  bus_rdata[CW-1:0] = txcnt_r;
            A_RXDATA: bus_rdata[7:0] = rx_dout;
            A_STATUS: begin
                bus_rdata[LW-1:0]          = rx_lvl;
                bus_rdata[TXLVL_LO +: LW]  = tx_lvl;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic        spi_mosi
);
    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    assert_level_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd6) |-> (bus_rdata[6:0] <= 7'd64 && bus_rdata[14:8] <= 7'd64));

    assert_srst_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd0 && bus_wdata[7]) |=> ##1 spi_cs_n);

    assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd0 && !bus_wdata[0] && spi_cs_n) |=> spi_cs_n);
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0, errs = 0, cyc = 0;
    int exp_half = 1, hi_len = 0, viol = 0, cs_falls = 0, sck_rises = 0;
    bit chk_sck = 1'b1, finished = 1'b0;
    logic sck_prev = 1'b0, mosi_prev = 1'b0;

    logic [7:0] miso_q[$], mosi_q[$], exp_rx[$];
    logic [7:0] sl_sh = 8'h00, mo_sh = 8'h00;
    int sl_cnt = 0, mo_n = 0;
    logic [15:0] v;

    spi_burst_master dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural slave: shifts out queued bytes, collects MOSI bytes
    assign spi_miso = sl_sh[7];
    always @(negedge spi_cs_n) begin
        cs_falls++;
        sl_sh  = (miso_q.size() != 0) ? miso_q.pop_front() : 8'h00;
        sl_cnt = 0;
        mo_n   = 0;
    end
    always @(posedge spi_sck) begin
        sck_rises++;
        mo_sh = {mo_sh[6:0], spi_mosi};
        mo_n++;
        if (mo_n == 8) begin
            mosi_q.push_back(mo_sh);
            mo_n = 0;
        end
    end
    always @(negedge spi_sck) begin
        sl_cnt++;
        if (sl_cnt == 8) begin
            sl_sh  = (miso_q.size() != 0) ? miso_q.pop_front() : 8'h00;
            sl_cnt = 0;
        end else sl_sh = {sl_sh[6:0], 1'b0};
    end

    // per-clock comparison of the serial timing against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sck) viol++;
            if (spi_sck && sck_prev && spi_mosi !== mosi_prev) viol++;
            if (spi_sck) hi_len++;
            else if (hi_len != 0) begin
                if (chk_sck) chk(hi_len == exp_half, "R7 sck high phase", hi_len, exp_half);
                hi_len = 0;
            end
        end
        sck_prev  = spi_sck;
        mosi_prev = spi_mosi;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++; errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic prep_slave(input int n, input int seed);
        miso_q.delete(); exp_rx.delete(); mosi_q.delete();
        for (int k = 0; k < n; k++) begin
            miso_q.push_back(8'(seed + k * 37) ^ 8'h5A);
            exp_rx.push_back(8'(seed + k * 37) ^ 8'h5A);
        end
    endtask

    task automatic run_burst();
        bus_write(3'd0, 16'h0013);
        repeat (2) @(negedge clk);
        while (spi_cs_n == 1'b0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int r0, f0;
        logic [7:0] expm[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd0, v); chk(v == 16'h0, "R1 ctrl after reset", v, 0);
        bus_read(3'd6, v); chk(v == 16'h0, "R1 status after reset", v, 0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 cs_n/sck idle", {spi_cs_n, spi_sck}, 2);

        // R2 start needs enable and master
        bus_write(3'd2, 16'd2);
        bus_write(3'd0, 16'h0010);
        bus_write(3'd0, 16'h0011);
        repeat (10) @(negedge clk);
        chk(cs_falls == 0, "R2 no burst without enable+master", cs_falls, 0);
        bus_read(3'd0, v); chk(v[4] == 1'b0, "R2 start bit not latched", v[4], 0);

        // R3 R4 R5 R7: command phase then receive-only phase, divide by 4
        bus_write(3'd1, 16'h1001); exp_half = 2;
        bus_write(3'd4, 16'h03); bus_write(3'd4, 16'h12);
        bus_write(3'd4, 16'h34); bus_write(3'd4, 16'h56);
        bus_write(3'd2, 16'd7); bus_write(3'd3, 16'd4);
        prep_slave(7, 3);
        r0 = sck_rises;
        bus_write(3'd0, 16'h0013);
        bus_read(3'd0, v); chk(v[4] == 1'b1, "R3 start bit set while busy", v[4], 1);
        repeat (2) @(negedge clk);
        while (spi_cs_n == 1'b0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sck_rises - r0 == 56, "R3 rising edges per burst", sck_rises - r0, 56);
        expm = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00};
        chk(mosi_q.size() == 7, "R4 bytes sent", mosi_q.size(), 7);
        for (int k = 0; k < 7 && k < mosi_q.size(); k++)
            chk(mosi_q[k] == expm[k], "R4 mosi byte", mosi_q[k], expm[k]);
        bus_read(3'd6, v);
        chk(v[6:0] == 7'd7, "R5 rx level", v[6:0], 7);
        chk(v[14:8] == 7'd0, "R5 tx level drained", v[14:8], 0);
        for (int k = 0; k < 7; k++) begin
            bus_read(3'd5, v); chk(v[7:0] == exp_rx[k], "R5 rx byte", v[7:0], exp_rx[k]);
        end
        bus_read(3'd0, v); chk(v == 16'h0003, "R3 start bit self-cleared", v, 3);

        // R4: transmit length beyond burst, divider off (R7)
        bus_write(3'd1, 16'h0000); exp_half = 1;
        bus_write(3'd4, 16'hAA); bus_write(3'd4, 16'hBB); bus_write(3'd4, 16'hCC);
        bus_write(3'd2, 16'd2); bus_write(3'd3, 16'd5);
        prep_slave(2, 91);
        run_burst();
        chk(mosi_q.size() == 2 && mosi_q[0] == 8'hAA && mosi_q[1] == 8'hBB,
            "R4 burst limits transmit", mosi_q.size(), 2);
        bus_read(3'd6, v); chk(v[14:8] == 7'd1, "R4 unsent byte stays queued", v[14:8], 1);
        for (int k = 0; k < 2; k++) begin
            bus_read(3'd5, v); chk(v[7:0] == exp_rx[k], "R5 rx byte fast clock", v[7:0], exp_rx[k]);
        end
        // R9 transmit queue clear
        bus_write(3'd0, 16'h0007);
        bus_read(3'd6, v); chk(v[14:8] == 7'd0, "R9 tx clear", v[14:8], 0);
        bus_read(3'd0, v); chk(v == 16'h0003, "R9 clear bits read 0", v, 3);
        // R4 empty queue sends zero
        bus_write(3'd2, 16'd3); bus_write(3'd3, 16'd3);
        prep_slave(3, 17);
        run_burst();
        chk(mosi_q.size() == 3 && mosi_q[0] == 8'h00 && mosi_q[1] == 8'h00 && mosi_q[2] == 8'h00,
            "R4 empty queue sends zero", mosi_q.size(), 3);
        bus_write(3'd0, 16'h000B);
        bus_read(3'd6, v); chk(v[6:0] == 7'd0, "R9 rx clear", v[6:0], 0);

        // R11 zero-length burst
        f0 = cs_falls;
        bus_write(3'd2, 16'd0);
        bus_write(3'd0, 16'h0013);
        repeat (3) @(negedge clk);
        bus_read(3'd0, v); chk(v[4] == 1'b0, "R11 start clears on zero burst", v[4], 0);
        chk(cs_falls == f0, "R11 no chip select", cs_falls - f0, 0);

        // R8 queue limits
        for (int k = 0; k < 65; k++) bus_write(3'd4, 16'(k));
        bus_read(3'd6, v); chk(v[14:8] == 7'd64, "R8 tx full drops write", v[14:8], 64);
        bus_write(3'd0, 16'h0007);
        bus_read(3'd5, v); chk(v == 16'h0, "R8 empty rx pop returns 0", v, 0);
        bus_read(3'd6, v); chk(v[6:0] == 7'd0, "R8 empty rx level stays 0", v[6:0], 0);
        bus_write(3'd2, 16'd70); bus_write(3'd3, 16'd0);
        prep_slave(70, 200);
        run_burst();
        bus_read(3'd6, v); chk(v[6:0] == 7'd64, "R8 rx overflow level", v[6:0], 64);
        bus_read(3'd5, v); chk(v[7:0] == exp_rx[0], "R8 oldest rx byte kept", v[7:0], exp_rx[0]);
        bus_write(3'd0, 16'h000B);

        // R10 soft reset aborts a running burst
        bus_write(3'd1, 16'h1001); exp_half = 2;
        bus_write(3'd2, 16'd20);
        prep_slave(20, 5);
        bus_write(3'd0, 16'h0013);
        repeat (40) @(negedge clk);
        chk_sck = 1'b0;
        bus_write(3'd0, 16'h0083);
        bus_read(3'd0, v); chk(v[7] == 1'b1, "R10 reset bit visible", v[7], 1);
        bus_read(3'd0, v); chk(v == 16'h0, "R10 reset bit self-clears", v, 0);
        chk(spi_cs_n == 1'b1, "R10 burst aborted", spi_cs_n, 1);
        bus_read(3'd6, v); chk(v == 16'h0, "R10 queues cleared", v, 0);
        bus_read(3'd1, v); chk(v == 16'h0, "R10 clock setup reset", v, 0);
        bus_read(3'd2, v); chk(v == 16'h0, "R10 burst length reset", v, 0);
        repeat (5) @(negedge clk);

        chk(viol == 0, "R6 mode 0 timing violations", viol, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule